// File: doc/BRIEF.md
# Word-Clock-Aligned Serial Audio Transmitter

This block turns a pair of parallel stereo samples into one serial data line. Each frame is 64 bit clocks long and holds two 32-bit fields: the left channel, then the right channel. The bit clock, the left/right clock and the word clock are all synchronous to the system clock `clk`, and the block samples them on that clock. A field begins at the bit-clock falling edge where the left/right clock changes level. Data changes on bit-clock falling edges so that a receiver can take it on rising edges.

Inside each field, a word-clock strobe chooses where the sample's MSB goes out. The sample then follows MSB first, and every other bit position carries zero. There is a deadline: if no strobe arrives early enough, the word is pushed to the right edge of the field, so its LSB still lands inside that field. A run-time select lets the block drive the word clock itself. In that mode every word is right-justified and the strobe input is ignored. Both samples are copied into holding registers at the start of each frame, so the parallel inputs may change at any time.

The sample width `WORD_W` is a parameter and must be 16 or 18. The left/right clock polarity that marks the left field is also a parameter.

Top module: `wclk_audio_tx`

## Requirements
- R1: A field starts at a bit-clock falling edge where `lrck` differs from its level at the previous falling edge. `lrck` high marks the left field (default `LEFT_HIGH`=1). Bits are numbered 1 to 32 from that edge, and bit 1 always carries 0.
- R2: With `wck_drive`=0, let k be the first bit of the field (k from 1 to 32-`WORD_W`) whose closing falling edge sees `wck_in` high. The MSB then goes out in bit k+1.
- R3: If no such edge has occurred by the end of bit 32-`WORD_W` (bit 14 for 18-bit words, bit 16 for 16-bit words), the MSB goes out in bit 33-`WORD_W` anyway. The strobe is not looked at after that point.
- R4: After the MSB, the remaining `WORD_W`-1 bits follow in consecutive bit periods, down to the LSB.
- R5: Every bit position before the MSB and after the LSB carries 0.
- R6: Only the first qualifying strobe in a field counts. Later strobes in the same field, including a strobe held high, have no effect until the next field starts.
- R7: With `wck_drive`=1, `wck_in` is ignored and the MSB goes out in bit 33-`WORD_W`. `wck_out` is high during exactly that bit period and low at every other time. With `wck_drive`=0, `wck_out` stays low.
- R8: `left_in` and `right_in` are both captured at the falling edge that starts a left field. A change to them later in the frame affects only the next frame.
- R9: After reset, and until the first `lrck` transition, `sdata` and `wck_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all other inputs are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bck | input | 1 | Bit clock |
| lrck | input | 1 | Left/right field clock |
| wck_in | input | 1 | Word-clock strobe; it marks where the MSB goes |
| wck_drive | input | 1 | 1: the block drives the word clock and right-justifies each word |
| left_in | input | WORD_W | Left-channel sample |
| right_in | input | WORD_W | Right-channel sample |
| sdata | output | 1 | Serial data, MSB first |
| wck_out | output | 1 | Word clock driven by the block; high during the MSB bit |

## Verification
The strobe-driven start and the deadline start can both fall on the same bit-clock edge, the end of bit 32-`WORD_W`. The bench raises `wck_in` so that it is sampled exactly at that edge, and also lets the deadline act alone. The scoreboard expects the MSB in bit 33-`WORD_W` in both cases, with exactly one word shifted out. A second overlap is a frame start together with a sample change. The bench changes both samples partway through a left field and checks that the change shows up only in the following frame.

// File: rtl/wclk_audio_tx_pkg.sv
package wclk_audio_tx_pkg;

   localparam int FIELD_BITS = 32;
   localparam int CNT_W      = $clog2(FIELD_BITS + 1);

   typedef logic [CNT_W-1:0] bitpos_t;

   // last bit whose closing edge may still start the word
   function automatic bitpos_t last_start_bit(input int word_w);
      return bitpos_t'(FIELD_BITS - word_w);
   endfunction

endpackage

// File: rtl/wclk_edge_sampler.sv
module wclk_edge_sampler #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bck,
   input  logic lrck,
   input  logic wck,
   output logic bck_fall,
   output logic lr_lvl,
   output logic wck_lvl
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("wclk_edge_sampler: STAGES must be at least 1");
      end
   endgenerate

   logic [2:0] pipe_q [STAGES];
   logic       bck_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= 3'b000;
         bck_prev_q <= 1'b0;
      end else begin
         pipe_q[0] <= {wck, lrck, bck};
         for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
         bck_prev_q <= pipe_q[STAGES-1][0];
      end
   end

   assign bck_fall = bck_prev_q & ~pipe_q[STAGES-1][0];
   assign lr_lvl   = pipe_q[STAGES-1][1];
   assign wck_lvl  = pipe_q[STAGES-1][2];

endmodule

// File: rtl/wclk_field_seq.sv
module wclk_field_seq
   import wclk_audio_tx_pkg::*;
#(
   parameter int WORD_W    = 18,
   parameter bit LEFT_HIGH = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    bck_fall,
   input  logic    lr_lvl,
   input  logic    wck_lvl,
   input  logic    wck_drive,
   output logic    field_start,
   output logic    capture,
   output logic    load,
   output logic    cur_left_q,
   output bitpos_t cnt_q,
   output logic    locked_q,
   output logic    started_q,
   output logic    wck_out_q
);

   localparam bitpos_t LAST_START = last_start_bit(WORD_W);
   localparam bitpos_t MSB_POS    = LAST_START + bitpos_t'(1);
   localparam bitpos_t FIELD_END  = bitpos_t'(FIELD_BITS);

   logic    lr_prev_q;
   logic    lr_change;
   logic    is_left_now;
   logic    strobe_hit;
   bitpos_t cnt_next;

   generate
      if (LEFT_HIGH) begin : g_left_high
         assign is_left_now = lr_lvl;
      end else begin : g_left_low
         assign is_left_now = ~lr_lvl;
      end
   endgenerate

   assign lr_change   = lr_lvl ^ lr_prev_q;
   assign field_start = bck_fall & lr_change;
   assign capture     = field_start & is_left_now;

   assign cnt_next   = (cnt_q == FIELD_END) ? cnt_q : cnt_q + bitpos_t'(1);
   assign strobe_hit = wck_drive ? (cnt_q == LAST_START)
                                 : (wck_lvl | (cnt_q == LAST_START));
   assign load       = bck_fall & locked_q & ~lr_change & ~started_q & strobe_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_prev_q  <= 1'b0;
         cnt_q      <= '0;
         locked_q   <= 1'b0;
         started_q  <= 1'b0;
         cur_left_q <= 1'b0;
         wck_out_q  <= 1'b0;
      end else if (bck_fall) begin
         lr_prev_q <= lr_lvl;
         if (lr_change) begin
            cnt_q      <= bitpos_t'(1);
            locked_q   <= 1'b1;
            started_q  <= 1'b0;
            cur_left_q <= is_left_now;
            wck_out_q  <= 1'b0;
         end else if (locked_q) begin
            cnt_q     <= cnt_next;
            wck_out_q <= wck_drive & (cnt_next == MSB_POS);
            if (load) started_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wclk_word_shifter.sv
module wclk_word_shifter #(
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              field_start,
   input  logic              capture,
   input  logic              load,
   input  logic              cur_left,
   input  logic [WORD_W-1:0] left_in,
   input  logic [WORD_W-1:0] right_in,
   output logic              sdata_q
);

   localparam int CH_N  = 2;
   localparam int REM_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] sample_in [CH_N];
   logic [WORD_W-1:0] hold_q    [CH_N];
   logic [WORD_W-1:0] shreg_q;
   logic [REM_W-1:0]  remain_q;
   logic [WORD_W-1:0] word_sel;

   assign sample_in[0] = left_in;
   assign sample_in[1] = right_in;

   genvar ch;
   generate
      for (ch = 0; ch < CH_N; ch++) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q[ch] <= '0;
            else if (capture) hold_q[ch] <= sample_in[ch];
         end
      end
   endgenerate

   assign word_sel = cur_left ? hold_q[0] : hold_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         remain_q <= '0;
         sdata_q  <= 1'b0;
      end else if (adv) begin
         if (field_start) begin
            remain_q <= '0;
            sdata_q  <= 1'b0;
         end else if (load) begin
            sdata_q  <= word_sel[WORD_W-1];
            shreg_q  <= word_sel << 1;
            remain_q <= REM_W'(WORD_W - 1);
         end else if (remain_q != '0) begin
            sdata_q  <= shreg_q[WORD_W-1];
            shreg_q  <= shreg_q << 1;
            remain_q <= remain_q - REM_W'(1);
         end else begin
            sdata_q  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wclk_audio_tx.sv
module wclk_audio_tx
   import wclk_audio_tx_pkg::*;
#(
   parameter int WORD_W    = 18,
   parameter bit LEFT_HIGH = 1'b1,
   parameter int IN_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bck,
   input  logic              lrck,
   input  logic              wck_in,
   input  logic              wck_drive,
   input  logic [WORD_W-1:0] left_in,
   input  logic [WORD_W-1:0] right_in,
   output logic              sdata,
   output logic              wck_out
);

   generate
      if (WORD_W != 16 && WORD_W != 18) begin : g_bad_width
         $error("wclk_audio_tx: WORD_W must be 16 or 18");
      end
   endgenerate

   logic    bck_fall, lr_lvl, wck_lvl;
   logic    field_start, capture, load;
   logic    cur_left, locked, started;
   bitpos_t field_cnt;

   wclk_edge_sampler #(.STAGES(IN_STAGES)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .bck      (bck),
      .lrck     (lrck),
      .wck      (wck_in),
      .bck_fall (bck_fall),
      .lr_lvl   (lr_lvl),
      .wck_lvl  (wck_lvl)
   );

   wclk_field_seq #(.WORD_W(WORD_W), .LEFT_HIGH(LEFT_HIGH)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bck_fall    (bck_fall),
      .lr_lvl      (lr_lvl),
      .wck_lvl     (wck_lvl),
      .wck_drive   (wck_drive),
      .field_start (field_start),
      .capture     (capture),
      .load        (load),
      .cur_left_q  (cur_left),
      .cnt_q       (field_cnt),
      .locked_q    (locked),
      .started_q   (started),
      .wck_out_q   (wck_out)
   );

   wclk_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv         (bck_fall),
      .field_start (field_start),
      .capture     (capture),
      .load        (load),
      .cur_left    (cur_left),
      .left_in     (left_in),
      .right_in    (right_in),
      .sdata_q     (sdata)
   );

endmodule

// File: rtl/wclk_audio_tx_chk.sv
module wclk_audio_tx_chk
   import wclk_audio_tx_pkg::*;
#(
   parameter int WORD_W = 18
) (
   input logic    clk,
   input logic    rst_n,
   input logic    sdata,
   input logic    wck_out,
   input logic    locked,
   input logic    started,
   input bitpos_t cnt
);

   localparam bitpos_t LAST_START = last_start_bit(WORD_W);
   localparam bitpos_t MSB_POS    = LAST_START + bitpos_t'(1);

   // R9
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> (!sdata && !wck_out));

   // R5
   zero_before_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !sdata);

   // R3
   deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && cnt > LAST_START) |-> started);

   // R7
   wck_out_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wck_out |-> (started && cnt == MSB_POS));

   // R1
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (cnt >= bitpos_t'(1) && cnt <= bitpos_t'(FIELD_BITS)));

   // R6
   start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(started) |-> cnt == bitpos_t'(1));

endmodule

bind wclk_audio_tx wclk_audio_tx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sdata   (sdata),
   .wck_out (wck_out),
   .locked  (locked),
   .started (started),
   .cnt     (field_cnt)
);

// File: tb/wclk_audio_tx_test.sv
module wclk_audio_tx_test;

   localparam int W  = 18;
   localparam int DL = 32 - W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bck = 1'b1;
   logic         lrck = 1'b0;
   logic         wck_in = 1'b0;
   logic         wck_drive = 1'b0;
   logic [W-1:0] left_in = '0;
   logic [W-1:0] right_in = '0;
   logic         sdata, wck_out;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic  d;
      logic  w;
      int    bitn;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   wclk_audio_tx #(.WORD_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .wck_in(wck_in),
      .wck_drive(wck_drive), .left_in(left_in), .right_in(right_in),
      .sdata(sdata), .wck_out(wck_out)
   );

   // monitor: compares every bit at the bit-clock rising edge
   always @(posedge bck) begin
      exp_t e;
      #1;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         checks++;
         if (sdata !== e.d) begin
            errors++;
            $display("FAIL %s bit %0d sdata=%b expected %b", e.tag, e.bitn, sdata, e.d);
         end
         checks++;
         if (wck_out !== e.w) begin
            errors++;
            $display("FAIL R7 bit %0d wck_out=%b expected %b", e.bitn, wck_out, e.w);
         end
      end
   end

   task automatic drive_bit(input logic lr, input logic w);
      bck  = 1'b0;
      lrck = lr;
      repeat (4) @(negedge clk);
      bck    = 1'b1;
      wck_in = w;
      repeat (4) @(negedge clk);
   endtask

   // driver: pushes the expected 32 bits of a field, then drives them
   task automatic run_field(input logic lr, input logic [W-1:0] word,
                            input logic [31:0] wmask, input string stag,
                            input bit poke, input logic [W-1:0] pl,
                            input logic [W-1:0] pr);
      int   s;
      bit   found;
      exp_t e;
      s = DL + 1;
      found = 1'b0;
      if (!wck_drive)
         for (int k = 1; k <= DL; k++)
            if (!found && wmask[k-1]) begin
               s = k + 1;
               found = 1'b1;
            end
      for (int k = 1; k <= 32; k++) begin
         e.bitn = k;
         e.w    = wck_drive && (k == DL + 1);
         if (k >= s && k < s + W) begin
            e.d   = word[W-1-(k-s)];
            e.tag = (k == s) ? stag : "R4";
         end else begin
            e.d   = 1'b0;
            e.tag = (k == 1) ? "R1" : "R5";
         end
         sb_q.push_back(e);
      end
      for (int k = 1; k <= 32; k++) begin
         if (poke && k == 10) begin
            left_in  = pl;
            right_in = pr;
         end
         drive_bit(lr, wmask[k-1]);
      end
   endtask

   task automatic run_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                            input logic [31:0] ml, input logic [31:0] mr,
                            input string tl, input string tr, input bit poke);
      left_in  = l;
      right_in = r;
      run_field(1'b1, l, ml, tl, poke, ~l, ~r);
      run_field(1'b0, r, mr, tr, 1'b0, '0, '0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL R1 watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      exp_t e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      checks++;
      if (sdata !== 1'b0 || wck_out !== 1'b0) begin
         errors++;
         $display("FAIL R9 reset sdata=%b wck_out=%b expected 0 0", sdata, wck_out);
      end
      // R9: idle bits before any lrck transition, strobe active
      for (int k = 1; k <= 4; k++) begin
         e.bitn = k; e.d = 1'b0; e.w = 1'b0; e.tag = "R9";
         sb_q.push_back(e);
      end
      for (int k = 1; k <= 4; k++) drive_bit(1'b0, 1'b1);

      // R2: strobe at bits 3 and 10
      run_frame(18'h2A5C3, 18'h15A3C, 32'h1 << 2, 32'h1 << 9, "R2", "R2", 1'b0);
      // R3: no strobe at all
      run_frame(18'h3FFFF, 18'h20001, 32'h0, 32'h0, "R3", "R3", 1'b0);
      // strobe exactly at the deadline bit, and at the earliest bit
      run_frame(18'h1C0F7, 18'h0A0A5, 32'h1 << (DL-1), 32'h1, "R3", "R2", 1'b0);
      // R6: two pulses, and a strobe held high all field
      run_frame(18'h3C3C3, 18'h12345, (32'h1 << 4) | (32'h1 << 8), 32'hFFFF_FFFF,
                "R6", "R6", 1'b0);
      // R3: strobes only after the deadline
      run_frame(18'h0F0F0, 18'h2DB6D, 32'h1 << 19, 32'hFFFF_8000, "R3", "R3", 1'b0);
      // R8: samples change in the middle of the left field
      run_frame(18'h13579, 18'h2468A, 32'h1 << 3, 32'h1 << 3, "R8", "R8", 1'b1);
      run_frame(18'h2BCDE, 18'h01F2E, 32'h1 << 5, 32'h1 << 6, "R8", "R8", 1'b0);
      // R7: block drives the word clock; strobe input ignored
      wck_drive = 1'b1;
      run_frame(18'h35A5A, 18'h0C3C3, 32'h1 << 2, 32'hFFFF_FFFF, "R7", "R7", 1'b0);
      run_frame(18'h00001, 18'h20000, 32'h0, 32'h1 << 6, "R7", "R7", 1'b0);
      wck_drive = 1'b0;
      run_frame(18'h1ABCD, 18'h3DCBA, 32'h1 << 6, 32'h1 << 11, "R2", "R2", 1'b0);

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule